// File: doc/BRIEF.md
# Deduplicating Write Mapping Controller

This block is the write path of a content-addressed page mapper. Each logical page write arrives with a logical page number and a hash of the page content. The block looks the hash up in a small on-chip hash cache. If the content is already stored, the logical page is pointed at the existing physical page and no flash program happens. If the content is new, the block takes a free physical page, raises a program request for it, and records the (hash, page) pair in the cache.

For each physical page the block keeps a count of the logical pages that map to it. When a remap takes that count to zero, the page is reported invalid, handed back to the free pool and dropped from the hash cache. Reads are plain translations through the logical-to-physical table and return a registered answer one cycle later. Hash computation, flash timing, garbage collection, wear leveling and table persistence are handled elsewhere.

Write requests use a valid/ready handshake. The block takes one write, then holds `wr_ready` low for exactly one cycle while it commits. The source must hold `wr_valid` and its payload stable until it sees `wr_ready` high at a clock edge. Each accepted write produces exactly one `done` pulse. Results, program requests and invalidations are single-cycle pulses with no back-pressure, so the consumer must take them when they appear.

Top module: `dedup_map_ctrl`

## Requirements
- R1: After reset, every logical page is unmapped, every physical page is free, the hash cache is empty, `wr_ready` is 1, and `done`, `prog_req` and `inval` are 0.
- R2: A write is accepted on a clock edge where `wr_valid` and `wr_ready` are both 1. `wr_ready` is 0 for the following cycle. `done` is 1 for exactly one cycle, starting at the next edge after acceptance.
- R3: A write whose hash misses the cache takes the lowest-numbered free physical page. It pulses `prog_req` with `prog_ppn` equal to that page, in the same cycle as `done` with `done_prog`=1 and `done_ppn` equal to the same page.
- R4: A write whose hash hits the cache issues no program request (`prog_req`=0, `done_prog`=0). It maps the logical page to the page the cache returned, and that page is shown on `done_ppn`.
- R5: Each physical page counts the logical pages mapped to it. When a remap takes a page's count to zero, `inval` pulses with `inval_ppn` equal to that page, in the same cycle as `done`. The page becomes free again, and any cache entry for it is removed. A removal that finds no entry has no effect.
- R6: A write that maps a logical page to the physical page it already uses changes no count and raises no invalidation.
- R7: A miss when no physical page is free ends with `done_err`=1, `done_prog`=0 and `done_ppn`=0. The mapping, the counts, the cache and the free pool are all left unchanged.
- R8: A write with a logical page number of at least NUM_LPN ends with `done_err`=2 and changes nothing. A read of such a number reports unmapped. `done_err`=0 means success.
- R9: A new cache entry goes into the lowest empty slot. If no slot is empty, it replaces the slot at a round-robin pointer that starts at slot 0 and advances by one after each such replacement. Content whose entry was evicted misses on its next write.
- R10: A read request (`rd_en`=1 at an edge) returns `rd_ack`=1 after that edge, with `rd_mapped` and `rd_ppn` giving the current translation of `rd_lpn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request ready |
| wr_lpn | input | LPN_W | Logical page number of the write |
| wr_hash | input | HASH_W | Content hash of the written page |
| done | output | 1 | One-cycle write completion pulse |
| done_prog | output | 1 | Completed write issued a flash program |
| done_ppn | output | PPN_W | Physical page the write was mapped to |
| done_err | output | 2 | 0 success, 1 no free page, 2 logical page out of range |
| prog_req | output | 1 | Page program request pulse |
| prog_ppn | output | PPN_W | Physical page to program |
| inval | output | 1 | Physical page invalidation pulse |
| inval_ppn | output | PPN_W | Physical page that lost its last reference |
| rd_en | input | 1 | Read translation request |
| rd_lpn | input | LPN_W | Logical page number to translate |
| rd_ack | output | 1 | Read result valid |
| rd_mapped | output | 1 | Logical page currently has a mapping |
| rd_ppn | output | PPN_W | Mapped physical page |

## Verification
A table of twenty writes drives a cache of four slots and a pool of eight pages through several patterns. First, one content is written to several logical pages, which separates a program from a pure remap. Next, logical pages leave a shared page one at a time, which separates a lower count from the zero count that invalidates. After that, the cache is filled until it evicts, so stored content misses and is stored a second time. The pool is then run dry while a hit still completes. Directed tests add a rewrite of the same content, whose effect only shows when the next remap invalidates, plus out-of-range page numbers, translations read back, and a reset in the middle of a run.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_NOSPACE = 2'd1,
    ERR_RANGE   = 2'd2
  } err_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_EXEC = 1'b1
  } state_e;
endpackage

// File: rtl/dmc_hash_cache.sv
module dmc_hash_cache #(
  parameter int HASH_W    = 128,
  parameter int PPN_IDX_W = 8,
  parameter int ENTRIES   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [HASH_W-1:0]    lk_hash,
  output logic                 lk_hit,
  output logic [PPN_IDX_W-1:0] lk_ppn,
  input  logic                 ins_en,
  input  logic [HASH_W-1:0]    ins_hash,
  input  logic [PPN_IDX_W-1:0] ins_ppn,
  input  logic                 rm_en,
  input  logic [PPN_IDX_W-1:0] rm_ppn
);
  localparam int SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic                 slot_vld [ENTRIES];
  logic [HASH_W-1:0]    slot_tag [ENTRIES];
  logic [PPN_IDX_W-1:0] slot_ppn [ENTRIES];
  logic [ENTRIES-1:0]   tag_hit;
  logic [ENTRIES-1:0]   ppn_hit;
  logic [SLOT_W-1:0]    rr_ptr;
  logic [SLOT_W-1:0]    empty_idx;
  logic                 has_empty;
  logic [SLOT_W-1:0]    ins_slot;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign tag_hit[g] = slot_vld[g] && (slot_tag[g] == lk_hash);
    assign ppn_hit[g] = slot_vld[g] && (slot_ppn[g] == rm_ppn);
  end

  always_comb begin
    lk_hit = |tag_hit;
    lk_ppn = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (tag_hit[i]) lk_ppn = slot_ppn[i];
    end
  end

  always_comb begin
    has_empty = 1'b0;
    empty_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!slot_vld[i]) begin
        has_empty = 1'b1;
        empty_idx = SLOT_W'(i);
      end
    end
  end

  assign ins_slot = has_empty ? empty_idx : rr_ptr;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_vld[g] <= 1'b0;
      end else begin
        if (rm_en && ppn_hit[g]) slot_vld[g] <= 1'b0;
        if (ins_en && (ins_slot == SLOT_W'(g))) begin
          slot_vld[g] <= 1'b1;
          slot_tag[g] <= ins_hash;
          slot_ppn[g] <= ins_ppn;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_ptr <= '0;
    end else if (ins_en && !has_empty) begin
      rr_ptr <= (rr_ptr == SLOT_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/dmc_page_alloc.sv
module dmc_page_alloc #(
  parameter int NUM_PPN = 256
) (
  input  logic                       clk,
  input  logic                       rst_n,
  output logic                       any_free,
  output logic [$clog2(NUM_PPN)-1:0] free_idx,
  input  logic                       take_en,
  input  logic [$clog2(NUM_PPN)-1:0] take_idx,
  input  logic                       rel_en,
  input  logic [$clog2(NUM_PPN)-1:0] rel_idx
);
  localparam int IDX_W = $clog2(NUM_PPN);

  logic [NUM_PPN-1:0] in_use;

  always_comb begin
    any_free = ~&in_use;
    free_idx = '0;
    for (int i = NUM_PPN - 1; i >= 0; i--) begin
      if (!in_use[i]) free_idx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_use <= '0;
    end else begin
      if (rel_en)  in_use[rel_idx]  <= 1'b0;
      if (take_en) in_use[take_idx] <= 1'b1;
    end
  end
endmodule

// File: rtl/dmc_map_table.sv
module dmc_map_table #(
  parameter int NUM_LPN = 256,
  parameter int NUM_PPN = 256
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(NUM_LPN)-1:0] wq_idx,
  output logic [$clog2(NUM_PPN)-1:0] wq_ppn,
  output logic                       wq_vld,
  input  logic [$clog2(NUM_LPN)-1:0] rq_idx,
  output logic [$clog2(NUM_PPN)-1:0] rq_ppn,
  output logic                       rq_vld,
  input  logic                       set_en,
  input  logic [$clog2(NUM_LPN)-1:0] set_lpn,
  input  logic [$clog2(NUM_PPN)-1:0] set_ppn,
  input  logic                       inc_en,
  input  logic [$clog2(NUM_PPN)-1:0] inc_idx,
  input  logic                       dec_en,
  input  logic [$clog2(NUM_PPN)-1:0] dec_idx,
  output logic                       dec_last
);
  localparam int PPN_IDX_W = $clog2(NUM_PPN);
  localparam int CNT_W     = $clog2(NUM_LPN + 1);

  logic [PPN_IDX_W-1:0] l2p     [NUM_LPN];
  logic [NUM_LPN-1:0]   l2p_vld;
  logic [CNT_W-1:0]     ref_cnt [NUM_PPN];

  assign wq_ppn   = l2p[wq_idx];
  assign wq_vld   = l2p_vld[wq_idx];
  assign rq_ppn   = l2p[rq_idx];
  assign rq_vld   = l2p_vld[rq_idx];
  assign dec_last = (ref_cnt[dec_idx] == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l2p_vld <= '0;
    end else if (set_en) begin
      l2p_vld[set_lpn] <= 1'b1;
      l2p[set_lpn]     <= set_ppn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PPN; i++) ref_cnt[i] <= '0;
    end else begin
      if (inc_en) ref_cnt[inc_idx] <= ref_cnt[inc_idx] + 1'b1;
      if (dec_en) ref_cnt[dec_idx] <= ref_cnt[dec_idx] - 1'b1;
    end
  end
endmodule

// File: rtl/dedup_map_ctrl.sv
module dedup_map_ctrl #(
  parameter int LPN_W         = 32,
  parameter int PPN_W         = 32,
  parameter int HASH_W        = 128,
  parameter int NUM_LPN       = 256,
  parameter int NUM_PPN       = 256,
  parameter int CACHE_ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [LPN_W-1:0]  wr_lpn,
  input  logic [HASH_W-1:0] wr_hash,
  output logic              done,
  output logic              done_prog,
  output logic [PPN_W-1:0]  done_ppn,
  output logic [1:0]        done_err,
  output logic              prog_req,
  output logic [PPN_W-1:0]  prog_ppn,
  output logic              inval,
  output logic [PPN_W-1:0]  inval_ppn,
  input  logic              rd_en,
  input  logic [LPN_W-1:0]  rd_lpn,
  output logic              rd_ack,
  output logic              rd_mapped,
  output logic [PPN_W-1:0]  rd_ppn
);
  import dmc_pkg::*;

  localparam int LPN_IDX_W = $clog2(NUM_LPN);
  localparam int PPN_IDX_W = $clog2(NUM_PPN);
  localparam int PPN_PAD   = PPN_W - PPN_IDX_W;

  state_e               state;
  logic [LPN_W-1:0]     req_lpn;
  logic [HASH_W-1:0]    req_hash;

  logic                 lpn_ok;
  logic [LPN_IDX_W-1:0] lpn_idx;
  logic                 c_hit;
  logic [PPN_IDX_W-1:0] c_ppn;
  logic [PPN_IDX_W-1:0] old_ppn;
  logic                 old_vld;
  logic                 any_free;
  logic [PPN_IDX_W-1:0] free_idx;
  logic                 last_ref;

  err_e                 res_err;
  logic                 res_prog;
  logic [PPN_IDX_W-1:0] new_ppn;
  logic                 commit;
  logic                 same_page;
  logic                 remap;
  logic                 drop_old;
  logic                 kill_old;

  logic                 rd_ok;
  logic [PPN_IDX_W-1:0] rq_ppn;
  logic                 rq_vld;

  // request capture and sequencing
  assign wr_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      req_lpn  <= '0;
      req_hash <= '0;
    end else begin
      case (state)
        ST_IDLE: if (wr_valid) begin
          state    <= ST_EXEC;
          req_lpn  <= wr_lpn;
          req_hash <= wr_hash;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // decision for the captured write
  assign lpn_ok  = (req_lpn < LPN_W'(NUM_LPN));
  assign lpn_idx = req_lpn[LPN_IDX_W-1:0];

  always_comb begin
    res_err  = ERR_NONE;
    res_prog = 1'b0;
    new_ppn  = '0;
    if (!lpn_ok) begin
      res_err = ERR_RANGE;
    end else if (c_hit) begin
      new_ppn = c_ppn;
    end else if (any_free) begin
      res_prog = 1'b1;
      new_ppn  = free_idx;
    end else begin
      res_err = ERR_NOSPACE;
    end
  end

  assign commit    = (state == ST_EXEC) && (res_err == ERR_NONE);
  assign same_page = old_vld && (old_ppn == new_ppn);
  assign remap     = commit && !same_page;
  assign drop_old  = remap && old_vld;
  assign kill_old  = drop_old && last_ref;

  dmc_hash_cache #(
    .HASH_W   (HASH_W),
    .PPN_IDX_W(PPN_IDX_W),
    .ENTRIES  (CACHE_ENTRIES)
  ) u_cache (
    .clk     (clk),
    .rst_n   (rst_n),
    .lk_hash (req_hash),
    .lk_hit  (c_hit),
    .lk_ppn  (c_ppn),
    .ins_en  (commit && res_prog),
    .ins_hash(req_hash),
    .ins_ppn (new_ppn),
    .rm_en   (kill_old),
    .rm_ppn  (old_ppn)
  );

  dmc_page_alloc #(
    .NUM_PPN(NUM_PPN)
  ) u_alloc (
    .clk     (clk),
    .rst_n   (rst_n),
    .any_free(any_free),
    .free_idx(free_idx),
    .take_en (commit && res_prog),
    .take_idx(new_ppn),
    .rel_en  (kill_old),
    .rel_idx (old_ppn)
  );

  assign rd_ok = (rd_lpn < LPN_W'(NUM_LPN));

  dmc_map_table #(
    .NUM_LPN(NUM_LPN),
    .NUM_PPN(NUM_PPN)
  ) u_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .wq_idx  (lpn_idx),
    .wq_ppn  (old_ppn),
    .wq_vld  (old_vld),
    .rq_idx  (rd_lpn[LPN_IDX_W-1:0]),
    .rq_ppn  (rq_ppn),
    .rq_vld  (rq_vld),
    .set_en  (remap),
    .set_lpn (lpn_idx),
    .set_ppn (new_ppn),
    .inc_en  (remap),
    .inc_idx (new_ppn),
    .dec_en  (drop_old),
    .dec_idx (old_ppn),
    .dec_last(last_ref)
  );

  // result pulses
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done      <= 1'b0;
      done_prog <= 1'b0;
      done_ppn  <= '0;
      done_err  <= 2'd0;
      prog_req  <= 1'b0;
      prog_ppn  <= '0;
      inval     <= 1'b0;
      inval_ppn <= '0;
    end else begin
      done     <= (state == ST_EXEC);
      prog_req <= commit && res_prog;
      inval    <= kill_old;
      if (state == ST_EXEC) begin
        done_prog <= commit && res_prog;
        done_err  <= res_err;
        done_ppn  <= commit ? {{PPN_PAD{1'b0}}, new_ppn} : '0;
      end
      if (commit && res_prog) prog_ppn  <= {{PPN_PAD{1'b0}}, new_ppn};
      if (kill_old)           inval_ppn <= {{PPN_PAD{1'b0}}, old_ppn};
    end
  end

  // read translation
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ack    <= 1'b0;
      rd_mapped <= 1'b0;
      rd_ppn    <= '0;
    end else begin
      rd_ack <= rd_en;
      if (rd_en) begin
        rd_mapped <= rd_ok && rq_vld;
        rd_ppn    <= (rd_ok && rq_vld) ? {{PPN_PAD{1'b0}}, rq_ppn} : '0;
      end
    end
  end
endmodule

// File: rtl/dedup_map_ctrl_chk.sv
module dedup_map_ctrl_chk #(
  parameter int PPN_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic             done,
  input logic             done_prog,
  input logic [PPN_W-1:0] done_ppn,
  input logic [1:0]       done_err,
  input logic             prog_req,
  input logic [PPN_W-1:0] prog_ppn,
  input logic             inval
);
  // R2
  accept_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !wr_ready);

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  prog_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> (done && done_prog && (prog_ppn == done_ppn)));

  // R7
  err_no_side_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (done_err != 2'd0)) |-> (!prog_req && !inval && !done_prog));

  // R5
  inval_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inval |-> (done && (done_err == 2'd0)));
endmodule

bind dedup_map_ctrl dedup_map_ctrl_chk #(.PPN_W(PPN_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .done     (done),
  .done_prog(done_prog),
  .done_ppn (done_ppn),
  .done_err (done_err),
  .prog_req (prog_req),
  .prog_ppn (prog_ppn),
  .inval    (inval)
);

// File: tb/dedup_map_ctrl_tb.sv
`timescale 1ns/1ps
module dedup_map_ctrl_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_valid = 1'b0;
  logic         wr_ready;
  logic [31:0]  wr_lpn = '0;
  logic [127:0] wr_hash = '0;
  logic         done, done_prog, prog_req, inval;
  logic [31:0]  done_ppn, prog_ppn, inval_ppn;
  logic [1:0]   done_err;
  logic         rd_en = 1'b0;
  logic [31:0]  rd_lpn = '0;
  logic         rd_ack, rd_mapped;
  logic [31:0]  rd_ppn;

  int n_run = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  dedup_map_ctrl #(
    .NUM_LPN(16), .NUM_PPN(8), .CACHE_ENTRIES(4)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_lpn(wr_lpn), .wr_hash(wr_hash),
    .done(done), .done_prog(done_prog), .done_ppn(done_ppn), .done_err(done_err),
    .prog_req(prog_req), .prog_ppn(prog_ppn), .inval(inval), .inval_ppn(inval_ppn),
    .rd_en(rd_en), .rd_lpn(rd_lpn), .rd_ack(rd_ack), .rd_mapped(rd_mapped), .rd_ppn(rd_ppn)
  );

  typedef struct packed {
    logic [31:0] lpn;
    logic [7:0]  hsh;
    logic        prog;
    logic [7:0]  ppn;
    logic [1:0]  err;
    logic        inv;
    logic [7:0]  ippn;
    logic [3:0]  tag;
  } vec_t;

  // hash letters: A=1 B=2 C=3 D=4 E=5 F=6 G=7 H=8 I=9
  localparam vec_t VEC [20] = '{
    '{32'd0,  8'd1, 1'b1, 8'd0, 2'd0, 1'b0, 8'd0, 4'd3},  // R3 new content
    '{32'd1,  8'd1, 1'b0, 8'd0, 2'd0, 1'b0, 8'd0, 4'd4},  // R4 duplicate
    '{32'd2,  8'd2, 1'b1, 8'd1, 2'd0, 1'b0, 8'd0, 4'd3},
    '{32'd0,  8'd2, 1'b0, 8'd1, 2'd0, 1'b0, 8'd0, 4'd5},  // R5 count 2->1
    '{32'd1,  8'd2, 1'b0, 8'd1, 2'd0, 1'b1, 8'd0, 4'd5},  // R5 count 1->0
    '{32'd3,  8'd3, 1'b1, 8'd0, 2'd0, 1'b0, 8'd0, 4'd3},  // R3 reuse freed page
    '{32'd3,  8'd3, 1'b0, 8'd0, 2'd0, 1'b0, 8'd0, 4'd6},  // R6 same page
    '{32'd4,  8'd4, 1'b1, 8'd2, 2'd0, 1'b0, 8'd0, 4'd3},
    '{32'd5,  8'd5, 1'b1, 8'd3, 2'd0, 1'b0, 8'd0, 4'd9},  // R9 cache full
    '{32'd6,  8'd6, 1'b1, 8'd4, 2'd0, 1'b0, 8'd0, 4'd9},  // R9 evict slot 0
    '{32'd7,  8'd3, 1'b1, 8'd5, 2'd0, 1'b0, 8'd0, 4'd9},  // R9 evicted -> miss
    '{32'd3,  8'd7, 1'b1, 8'd6, 2'd0, 1'b1, 8'd0, 4'd5},  // R5 remove absent entry
    '{32'd0,  8'd2, 1'b1, 8'd0, 2'd0, 1'b0, 8'd0, 4'd9},
    '{32'd20, 8'd1, 1'b0, 8'd0, 2'd2, 1'b0, 8'd0, 4'd8},  // R8 out of range
    '{32'd8,  8'd8, 1'b1, 8'd7, 2'd0, 1'b0, 8'd0, 4'd3},
    '{32'd9,  8'd9, 1'b0, 8'd0, 2'd1, 1'b0, 8'd0, 4'd7},  // R7 pool empty
    '{32'd9,  8'd3, 1'b0, 8'd5, 2'd0, 1'b0, 8'd0, 4'd7},  // R7 hit still works
    '{32'd7,  8'd8, 1'b0, 8'd7, 2'd0, 1'b0, 8'd0, 4'd5},
    '{32'd9,  8'd8, 1'b0, 8'd7, 2'd0, 1'b1, 8'd5, 4'd5},
    '{32'd10, 8'd3, 1'b1, 8'd5, 2'd0, 1'b0, 8'd0, 4'd5}   // R5 entry was removed
  };

  logic        g_done, g_prog, g_inv, g_stall, g_preq;
  logic [31:0] g_ppn, g_ippn, g_pppn;
  logic [1:0]  g_err;

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic do_write(input logic [31:0] lpn, input logic [127:0] h);
    @(negedge clk);
    wr_valid = 1'b1; wr_lpn = lpn; wr_hash = h;
    @(negedge clk);
    wr_valid = 1'b0;
    g_stall = !wr_ready && !done;
    @(negedge clk);
    g_done = done; g_prog = done_prog; g_ppn = done_ppn; g_err = done_err;
    g_inv = inval; g_ippn = inval_ppn; g_preq = prog_req; g_pppn = prog_ppn;
  endtask

  task automatic do_read(input logic [31:0] lpn, output logic ack, output logic mapped, output logic [31:0] ppn);
    @(negedge clk);
    rd_en = 1'b1; rd_lpn = lpn;
    @(negedge clk);
    rd_en = 1'b0;
    ack = rd_ack; mapped = rd_mapped; ppn = rd_ppn;
  endtask

  task automatic chk_read(input logic [31:0] lpn, input logic exp_m, input logic [31:0] exp_p, input string tag);
    logic a, m;
    logic [31:0] p;
    do_read(lpn, a, m, p);
    chk(a && (m == exp_m) && (p == exp_p), $sformatf("%s read lpn %0d", tag, lpn),
        {31'd0, a, m, p}, {31'd0, 1'b1, exp_m, exp_p});
  endtask

  task automatic chk_write(input logic [31:0] lpn, input logic [127:0] h, input logic e_prog,
                           input logic [31:0] e_ppn, input logic [1:0] e_err, input logic e_inv,
                           input logic [31:0] e_ippn, input string tag);
    logic [63:0] act, exp;
    do_write(lpn, h);
    act = {g_done, g_prog, g_err, g_inv, 3'd0, g_ppn[7:0], (g_inv ? g_ippn[7:0] : 8'd0), 32'd0};
    exp = {1'b1, e_prog, e_err, e_inv, 3'd0, e_ppn[7:0], (e_inv ? e_ippn[7:0] : 8'd0), 32'd0};
    chk(act == exp && g_stall && (g_preq == e_prog) && (!e_prog || g_pppn == e_ppn),
        $sformatf("%s write lpn %0d", tag, lpn), act, exp);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin : stim
    logic a, m;
    logic [31:0] p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(wr_ready && !done && !prog_req && !inval, "R1 idle outputs after reset",
        {60'd0, wr_ready, done, prog_req, inval}, {60'd0, 4'b1000});
    do_read(32'd0, a, m, p);
    chk(a && !m, "R1 lpn 0 unmapped after reset", {62'd0, a, m}, {62'd0, 2'b10});

    // main vector table
    for (int i = 0; i < 20; i++) begin
      chk_write(VEC[i].lpn, {120'd0, VEC[i].hsh}, VEC[i].prog, {24'd0, VEC[i].ppn},
                VEC[i].err, VEC[i].inv, {24'd0, VEC[i].ippn},
                $sformatf("R%0d R2 vec %0d", VEC[i].tag, i));
    end

    // R10 translations after the table
    chk_read(32'd0,  1'b1, 32'd0, "R10");
    chk_read(32'd3,  1'b1, 32'd6, "R10");
    chk_read(32'd9,  1'b1, 32'd7, "R10");
    chk_read(32'd11, 1'b0, 32'd0, "R10");
    chk_read(32'd20, 1'b0, 32'd0, "R8");

    // R6 rewrite of the same page must leave the count at 1
    chk_write(32'd10, 128'd3, 1'b0, 32'd5, 2'd0, 1'b0, 32'd0, "R6 same content");
    chk_write(32'd10, 128'd8, 1'b0, 32'd7, 2'd0, 1'b1, 32'd5, "R6 count unchanged");

    // R2 done is a single-cycle pulse
    @(negedge clk);
    chk(!done && wr_ready, "R2 done low and ready high after pulse",
        {62'd0, done, wr_ready}, {62'd0, 2'b01});

    // R1 reset in the middle of a run
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wr_ready && !done, "R1 idle after mid-run reset", {62'd0, wr_ready, done}, {62'd0, 2'b10});
    chk_read(32'd0, 1'b0, 32'd0, "R1");
    chk_write(32'd0, 128'd1, 1'b1, 32'd0, 2'd0, 1'b0, 32'd0, "R1 cache and pool empty");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule